// File: doc/BRIEF.md
# Coprocessor Bus Region Decoder

This block sits between a coprocessor core and its byte-wide memory system. It takes a request (32-bit address, read or write, byte or word size, instruction-fetch flag, write data). The top three address bits pick one of eight regions. The block then drives the matching memory port with a masked address, or produces the read byte itself.

Program ROM, data ROM and program RAM are external synchronous memories. A small register window is reached through an I/O sub-port. Three unmapped regions read back a byte of the most recently fetched instruction word. One region reads back a byte of a hard-wired constant.

A word request is carried out as four byte beats on the byte-wide side, and the read bytes are packed little-endian. Every beat, whatever its source, takes the same number of cycles, so the response time depends only on the request size.

Top module: `cbd_bus_decoder`

## Requirements
- R1: With address bits [31:29] = 0, a read asserts `prom_en` with `prom_addr` = address bits [16:0] and returns the ROM byte.
- R2: With address bits [31:29] = 5, a read asserts `drom_en` with `drom_addr` = address bits [14:0] and returns the ROM byte.
- R3: With address bits [31:29] = 7, reads and writes use program RAM at `pram_addr` = address bits [13:0]. A write asserts `pram_we`, and data written is returned by later reads.
- R4: With address bits [31:29] = 1, 4 or 6, a read returns byte n of the stored instruction word, where n = address bits [1:0] and byte 0 is bits [7:0].
- R5: With address bits [31:29] = 3, a read returns byte n (n = address bits [1:0], byte 0 least significant) of the constant 0x40404001.
- R6: With address bits [31:29] = 2, each beat pulses `io_rd` or `io_wr` once, with `io_addr` = address AND 0xE000003F and the beat's write byte on `io_wdata`.
- R7: An I/O-window read beat returns `io_rdata` when `io_hit` is high and 0x00 when it is low.
- R8: A word request (`req_word`=1) clears address bits [1:0] and makes four beats at offsets 0, 1, 2, 3 in that order. Beat k writes `req_wdata[8k+7:8k]`, and read beat k fills `rsp_rdata[8k+7:8k]`. A byte request writes `req_wdata[7:0]` and returns its byte zero-extended.
- R9: A write to any region other than 2 and 7 produces no `pram_we` and no `io_wr` strobe and changes no stored data.
- R10: The stored instruction word is zero after reset. It is loaded with the full response of each read that has `req_fetch`=1, and is left unchanged by any other request.
- R11: After reset, `req_ready` is 1 and `rsp_valid` is 0. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` then stays low until the response. `rsp_valid` is a one-cycle pulse arriving RD_LAT+1 edges after acceptance for a byte request and 4*(RD_LAT+1) edges after acceptance for a word request.
- R12: At most one of `prom_en`, `drom_en`, `pram_en`, `io_rd`, `io_wr` is high in any cycle, and none is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to accept a request |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_wdata | input | 32 | Write data (byte access uses bits [7:0]) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read result (zero for writes) |
| prom_en | output | 1 | Program ROM read enable |
| prom_addr | output | 17 | Program ROM byte address |
| prom_rdata | input | 8 | Program ROM data, RD_LAT cycles after enable |
| drom_en | output | 1 | Data ROM read enable |
| drom_addr | output | 15 | Data ROM byte address |
| drom_rdata | input | 8 | Data ROM data |
| pram_en | output | 1 | Program RAM enable |
| pram_we | output | 1 | Program RAM write enable |
| pram_addr | output | 14 | Program RAM byte address |
| pram_wdata | output | 8 | Program RAM write byte |
| pram_rdata | input | 8 | Program RAM read data |
| io_rd | output | 1 | I/O register read strobe |
| io_wr | output | 1 | I/O register write strobe |
| io_addr | output | 32 | Reduced I/O address |
| io_wdata | output | 8 | I/O write byte |
| io_rdata | input | 8 | I/O read byte |
| io_hit | input | 1 | A register claimed the I/O read |

## Verification
With the default RD_LAT of 1, a byte request completes two edges after acceptance and a word request completes eight edges after acceptance. Memory strobes appear in the cycle right after acceptance and in every second cycle after that. The bench accepts each request on a rising edge and then counts falling edges until `rsp_valid` is seen. It checks that count against the size-based figure and samples the data on that same falling edge. Strobe counts, the last strobed addresses and the stored instruction word are compared only after the response, when every beat of the request has taken effect.

// File: rtl/cbd_pkg.sv
// Package: shared types and constants for the coprocessor bus region decoder.
// Assumes a 32-bit byte address whose top three bits select the region.
package cbd_pkg;

    localparam int ADDR_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int REGION_W = 3;

    // Region selected by address bits [31:29]; the numbering is fixed by the bus map.
    typedef enum logic [REGION_W-1:0] {
        RGN_PROM   = 3'd0,
        RGN_OPC_A  = 3'd1,
        RGN_IO     = 3'd2,
        RGN_FIXED  = 3'd3,
        RGN_OPC_B  = 3'd4,
        RGN_DROM   = 3'd5,
        RGN_OPC_C  = 3'd6,
        RGN_PRAM   = 3'd7
    } region_e;

    // Beat sequencer states.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    // Hard-wired word returned by the constant region.
    localparam logic [WORD_W-1:0] FIXED_WORD = 32'h4040_4001;

    // Picks byte 'sel' of a word, byte 0 being the least significant.
    function automatic logic [BYTE_W-1:0] pick_lane(input logic [WORD_W-1:0] w,
                                                     input logic [1:0] sel);
        return w[{sel, 3'b000} +: BYTE_W];
    endfunction

endpackage

// File: rtl/cbd_region_decode.sv
// Module: cbd_region_decode
// Combinational decode of one beat address into a region code and the masked
// address for each memory port. Assumes the address is stable for the whole beat.
module cbd_region_decode
    import cbd_pkg::*;
#(
    parameter int PROM_AW = 17,
    parameter int DROM_AW = 15,
    parameter int PRAM_AW = 14,
    parameter int IO_AW   = 6
) (
    input  logic [ADDR_W-1:0]  beat_addr,
    output region_e            region,
    output logic [PROM_AW-1:0] prom_addr,
    output logic [DROM_AW-1:0] drom_addr,
    output logic [PRAM_AW-1:0] pram_addr,
    output logic [ADDR_W-1:0]  io_addr,
    output logic [1:0]         lane_sel
);

    localparam int RGN_LSB = ADDR_W - REGION_W;
    localparam int IO_GAP  = RGN_LSB - IO_AW;

    // Region code and byte lane come straight from fixed address fields.
    always_comb begin
        region   = region_e'(beat_addr[ADDR_W-1:RGN_LSB]);
        lane_sel = beat_addr[1:0];
    end

    // Each memory sees only the low bits that index its own storage.
    always_comb begin
        prom_addr = beat_addr[PROM_AW-1:0];
        drom_addr = beat_addr[DROM_AW-1:0];
        pram_addr = beat_addr[PRAM_AW-1:0];
    end

    // I/O window keeps the region bits and the low register-select bits only.
    always_comb begin
        io_addr = {beat_addr[ADDR_W-1:RGN_LSB], {IO_GAP{1'b0}}, beat_addr[IO_AW-1:0]};
    end

    // Middle address bits select nothing in any region.
    logic unused_mid_bits;
    assign unused_mid_bits = ^beat_addr[RGN_LSB-1:PROM_AW];

endmodule

// File: rtl/cbd_beat_seq.sv
// Module: cbd_beat_seq
// Steps a request through one or four byte beats. Each beat has one issue
// cycle followed by RD_LAT cycles of waiting, and the last waiting cycle is
// the capture cycle. Assumes RD_LAT >= 1 and that start is only raised while idle.
module cbd_beat_seq
    import cbd_pkg::*;
#(
    parameter int RD_LAT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_word,
    output logic       busy,
    output logic       issue,
    output logic       capture,
    output logic       last_beat,
    output logic [1:0] beat_idx
);

    localparam int CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RD_LAT - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] wait_cnt;
    logic             word_q;

    // Decoded phase strobes for the current beat.
    always_comb begin
        busy      = (state != SEQ_IDLE);
        issue     = (state == SEQ_ISSUE);
        capture   = (state == SEQ_WAIT) && (wait_cnt == '0);
        last_beat = !word_q || (beat_idx == 2'd3);
    end

    // State, beat index and latency counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            wait_cnt <= '0;
            beat_idx <= 2'd0;
            word_q   <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state    <= SEQ_ISSUE;
                        beat_idx <= 2'd0;
                        word_q   <= is_word;
                    end
                end
                SEQ_ISSUE: begin
                    state    <= SEQ_WAIT;
                    wait_cnt <= CNT_LOAD;
                end
                SEQ_WAIT: begin
                    if (wait_cnt != '0) begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end else if (last_beat) begin
                        state <= SEQ_IDLE;
                    end else begin
                        beat_idx <= beat_idx + 2'd1;
                        state    <= SEQ_ISSUE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R8: a capture that is not the last one is followed directly by the next issue.
    a_r8_next_beat_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !last_beat) |=> (issue && beat_idx == $past(beat_idx) + 2'd1));

    // R11: a new request is never started while a request is in flight.
    a_r11_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(capture && last_beat)) |=> busy);

endmodule

// File: rtl/cbd_word_asm.sv
// Module: cbd_word_asm
// Packs captured bytes into a little-endian word, emits the one-cycle
// response and holds the last fetched instruction word. Assumes capture pulses
// arrive at most once per beat with beat_idx stable.
module cbd_word_asm
    import cbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              last_beat,
    input  logic [1:0]        beat_idx,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              is_fetch,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic [WORD_W-1:0] opcode
);

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] acc_next;

    // Insert the captured byte into its lane of the partial word.
    always_comb begin
        acc_next = acc;
        acc_next[{beat_idx, 3'b000} +: BYTE_W] = byte_in;
    end

    // Accumulate lanes and publish the word on the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (capture) begin
                if (last_beat) begin
                    acc       <= '0;
                    rsp_valid <= 1'b1;
                    rsp_rdata <= acc_next;
                end else begin
                    acc <= acc_next;
                end
            end
        end
    end

    // Instruction word register, loaded only by completed fetches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= '0;
        end else if (capture && last_beat && is_fetch) begin
            opcode <= acc_next;
        end
    end

    // R11: the response strobe never lasts more than one cycle.
    a_r11_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: the instruction word changes only at the end of a fetch.
    a_r10_opcode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture && last_beat && is_fetch) |=> $stable(opcode));

    // R10: after a fetch completes, the stored word equals the response.
    a_r10_opcode_matches_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && last_beat && is_fetch) |=> (opcode == rsp_rdata));

endmodule

// File: rtl/cbd_bus_decoder.sv
// Module: cbd_bus_decoder (top)
// Accepts one request at a time, splits it into byte beats, routes each beat
// to its region and assembles the read result. Assumes every external memory
// and the I/O port return read data exactly RD_LAT cycles after the strobe.
module cbd_bus_decoder
    import cbd_pkg::*;
#(
    parameter int PROM_AW = 17,
    parameter int DROM_AW = 15,
    parameter int PRAM_AW = 14,
    parameter int IO_AW   = 6,
    parameter int RD_LAT  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_addr,
    input  logic               req_write,
    input  logic               req_word,
    input  logic               req_fetch,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               prom_en,
    output logic [PROM_AW-1:0] prom_addr,
    input  logic [7:0]         prom_rdata,
    output logic               drom_en,
    output logic [DROM_AW-1:0] drom_addr,
    input  logic [7:0]         drom_rdata,
    output logic               pram_en,
    output logic               pram_we,
    output logic [PRAM_AW-1:0] pram_addr,
    output logic [7:0]         pram_wdata,
    input  logic [7:0]         pram_rdata,
    output logic               io_rd,
    output logic               io_wr,
    output logic [31:0]        io_addr,
    output logic [7:0]         io_wdata,
    input  logic [7:0]         io_rdata,
    input  logic               io_hit
);

    logic              start;
    logic              busy;
    logic              issue;
    logic              capture;
    logic              last_beat;
    logic [1:0]        beat_idx;

    logic [ADDR_W-1:0] q_addr;
    logic              q_write;
    logic              q_word;
    logic              q_fetch;
    logic [WORD_W-1:0] q_wdata;

    logic [ADDR_W-1:0] beat_addr;
    region_e           region;
    logic [1:0]        lane_sel;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] cap_byte;
    logic [WORD_W-1:0] opcode;

    // Handshake: a request is taken whenever the sequencer is idle.
    always_comb begin
        req_ready = !busy;
        start     = req_valid && req_ready;
    end

    // Hold the accepted request for the duration of its beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_write <= 1'b0;
            q_word  <= 1'b0;
            q_fetch <= 1'b0;
            q_wdata <= '0;
        end else if (start) begin
            q_addr  <= req_addr;
            q_write <= req_write;
            q_word  <= req_word;
            q_fetch <= req_fetch && !req_write;
            q_wdata <= req_wdata;
        end
    end

    // Beat address: word requests walk offsets 0..3 from an aligned base.
    always_comb begin
        beat_addr = {q_addr[ADDR_W-1:2], (q_word ? beat_idx : q_addr[1:0])};
        wr_byte   = q_word ? q_wdata[{beat_idx, 3'b000} +: BYTE_W] : q_wdata[BYTE_W-1:0];
    end

    cbd_beat_seq #(
        .RD_LAT (RD_LAT)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_word   (req_word),
        .busy      (busy),
        .issue     (issue),
        .capture   (capture),
        .last_beat (last_beat),
        .beat_idx  (beat_idx)
    );

    cbd_region_decode #(
        .PROM_AW (PROM_AW),
        .DROM_AW (DROM_AW),
        .PRAM_AW (PRAM_AW),
        .IO_AW   (IO_AW)
    ) dec_i (
        .beat_addr (beat_addr),
        .region    (region),
        .prom_addr (prom_addr),
        .drom_addr (drom_addr),
        .pram_addr (pram_addr),
        .io_addr   (io_addr),
        .lane_sel  (lane_sel)
    );

    // Per-region strobes, issued for one cycle per beat; writes reach only RAM and I/O.
    always_comb begin
        prom_en    = issue && !q_write && (region == RGN_PROM);
        drom_en    = issue && !q_write && (region == RGN_DROM);
        pram_en    = issue && (region == RGN_PRAM);
        pram_we    = issue && q_write && (region == RGN_PRAM);
        io_rd      = issue && !q_write && (region == RGN_IO);
        io_wr      = issue && q_write && (region == RGN_IO);
        pram_wdata = wr_byte;
        io_wdata   = wr_byte;
    end

    // Select the byte returned by this beat's source; writes return zero.
    always_comb begin
        case (region)
            RGN_PROM:  cap_byte = prom_rdata;
            RGN_DROM:  cap_byte = drom_rdata;
            RGN_PRAM:  cap_byte = pram_rdata;
            RGN_IO:    cap_byte = io_hit ? io_rdata : '0;
            RGN_FIXED: cap_byte = pick_lane(FIXED_WORD, lane_sel);
            default:   cap_byte = pick_lane(opcode, lane_sel);
        endcase
        if (q_write) begin
            cap_byte = '0;
        end
    end

    cbd_word_asm asm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .last_beat (last_beat),
        .beat_idx  (beat_idx),
        .byte_in   (cap_byte),
        .is_fetch  (q_fetch),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .opcode    (opcode)
    );

    // R12: memory-side strobes are mutually exclusive.
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prom_en, drom_en, pram_en, io_rd, io_wr}));

    // R12: no strobe while the block is idle.
    a_r12_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(prom_en || drom_en || pram_en || io_rd || io_wr));

    // R6: the I/O port only ever sees addresses inside the reduced window.
    a_r6_io_window_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> (io_addr[31:29] == 3'b010 && io_addr[28:IO_AW] == '0));

    // R9: a RAM write strobe always comes with the RAM enable.
    a_r9_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        pram_we |-> pram_en);

    // R11: an accepted request drops ready on the next cycle.
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/cbd_bus_decoder_tb.sv
// Bench: directed corner cases plus seeded random requests, each checked
// against bench-side models of the memories and of the expected decode.
module cbd_bus_decoder_tb_top;

    localparam int LAT = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic        req_fetch = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        prom_en, drom_en, pram_en, pram_we, io_rd, io_wr, io_hit;
    logic [16:0] prom_addr;
    logic [14:0] drom_addr;
    logic [13:0] pram_addr;
    logic [31:0] io_addr;
    logic [7:0]  prom_rdata, drom_rdata, pram_rdata, pram_wdata, io_rdata, io_wdata;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    cbd_bus_decoder #(.RD_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_word(req_word), .req_fetch(req_fetch),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .prom_en(prom_en), .prom_addr(prom_addr), .prom_rdata(prom_rdata),
        .drom_en(drom_en), .drom_addr(drom_addr), .drom_rdata(drom_rdata),
        .pram_en(pram_en), .pram_we(pram_we), .pram_addr(pram_addr),
        .pram_wdata(pram_wdata), .pram_rdata(pram_rdata),
        .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_hit(io_hit)
    );

    // ---------------- memory and I/O models ----------------
    function automatic logic [7:0] prom_val(input logic [16:0] a);
        return a[7:0] ^ a[16:9] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] drom_val(input logic [14:0] a);
        return ~a[7:0] ^ {1'b0, a[14:8]};
    endfunction
    function automatic logic io_claims(input logic [5:0] a);
        return (a == 6'h10) || (a == 6'h20);
    endfunction

    logic [7:0]  ram [256];
    logic [7:0]  ram_m [256];
    int          pram_we_cnt = 0;
    int          io_wr_cnt = 0;
    logic [16:0] last_prom_addr = '0;
    logic [14:0] last_drom_addr = '0;
    logic [13:0] last_pram_addr = '0;
    logic [31:0] last_io_addr = '0;
    logic [7:0]  last_io_wdata = '0;

    always @(posedge clk) begin
        if (prom_en) begin
            prom_rdata     <= prom_val(prom_addr);
            last_prom_addr <= prom_addr;
        end
        if (drom_en) begin
            drom_rdata     <= drom_val(drom_addr);
            last_drom_addr <= drom_addr;
        end
        if (pram_en) begin
            last_pram_addr <= pram_addr;
            if (pram_we) begin
                ram[pram_addr[7:0]] <= pram_wdata;
                pram_we_cnt         <= pram_we_cnt + 1;
            end else begin
                pram_rdata <= ram[pram_addr[7:0]];
            end
        end
        if (io_rd) begin
            io_hit       <= io_claims(io_addr[5:0]);
            io_rdata     <= io_claims(io_addr[5:0]) ? (8'h3C ^ {2'b00, io_addr[5:0]}) : 8'hEE;
            last_io_addr <= io_addr;
        end
        if (io_wr) begin
            io_wr_cnt     <= io_wr_cnt + 1;
            last_io_addr  <= io_addr;
            last_io_wdata <= io_wdata;
        end
    end

    // ---------------- expected-value model ----------------
    logic [31:0] opc_m = '0;

    function automatic logic [7:0] exp_byte(input logic [31:0] a);
        logic [31:0] k = 32'h4040_4001;
        case (a[31:29])
            3'd0: return prom_val(a[16:0]);
            3'd5: return drom_val(a[14:0]);
            3'd7: return ram_m[a[7:0]];
            3'd3: return k[a[1:0]*8 +: 8];
            3'd2: return io_claims(a[5:0]) ? (8'h3C ^ {2'b00, a[5:0]}) : 8'h00;
            default: return opc_m[a[1:0]*8 +: 8];
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a, input logic wd);
        logic [31:0] r = '0;
        if (!wd) return {24'h0, exp_byte(a)};
        for (int k = 0; k < 4; k++) r[k*8 +: 8] = exp_byte({a[31:2], 2'(k)});
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] r);
        case (r)
            3'd0: return "R1";
            3'd5: return "R2";
            3'd7: return "R3";
            3'd3: return "R5";
            3'd2: return "R7";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One complete request: drive, time the response, check data and side effects.
    task automatic access(input logic [31:0] a, input logic w, input logic wd,
                          input logic f, input logic [31:0] d);
        logic [31:0] expd = exp_read(a, wd);
        logic [2:0]  rg = a[31:29];
        int we0 = pram_we_cnt;
        int io0 = io_wr_cnt;
        int n = 0;
        int exp_we = (w && rg == 3'd7) ? (wd ? 4 : 1) : 0;
        int exp_io = (w && rg == 3'd2) ? (wd ? 4 : 1) : 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R11 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a; req_write = w; req_word = wd;
        req_fetch = f; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R11 busy after accept", 32'(req_ready), 32'd0);
        while (n < 40) begin
            @(negedge clk);
            n++;
            if (rsp_valid) break;
        end
        check(n == (wd ? 4 * (LAT + 1) : LAT + 1), "R11 response latency", 32'(n),
              32'(wd ? 4 * (LAT + 1) : LAT + 1));
        if (!w) begin
            check(rsp_rdata == expd, wd ? {tag_of(rg), "/R8 word read"} : tag_of(rg),
                  rsp_rdata, expd);
        end else begin
            check(rsp_rdata == 32'h0, "R8 write returns zero", rsp_rdata, 32'h0);
            for (int k = 0; k < (wd ? 4 : 1); k++) begin
                if (rg == 3'd7) ram_m[{a[7:2], (wd ? 2'(k) : a[1:0])}] = d[k*8 +: 8];
            end
        end
        @(negedge clk);
        check(pram_we_cnt - we0 == exp_we, "R9 RAM write strobe count",
              32'(pram_we_cnt - we0), 32'(exp_we));
        check(io_wr_cnt - io0 == exp_io, "R9 I/O write strobe count",
              32'(io_wr_cnt - io0), 32'(exp_io));
        if (f && !w) opc_m = expd;
    endtask

    // Watchdog: a hung run is a failed check and still reports the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]   = 8'h00;
            ram_m[i] = 8'h00;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11/R12: reset state.
        check(req_ready == 1'b1, "R11 reset ready", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check({prom_en, drom_en, pram_en, io_rd, io_wr} == 5'b0, "R12 idle strobes",
              32'({prom_en, drom_en, pram_en, io_rd, io_wr}), 32'd0);

        // R10: instruction word is zero after reset.
        access(32'h8000_0000, 1'b0, 1'b1, 1'b0, 32'h0);
        check(rsp_rdata == 32'h0, "R10 reset instruction word", rsp_rdata, 32'h0);

        // R1: program ROM masking.
        access(32'h0003_0005, 1'b0, 1'b0, 1'b0, 32'h0);
        check(last_prom_addr == 17'h1_0005, "R1 prom_addr mask", 32'(last_prom_addr), 32'h1_0005);
        // R2: data ROM masking.
        access(32'hA001_C0DE, 1'b0, 1'b0, 1'b0, 32'h0);
        check(last_drom_addr == 15'h40DE, "R2 drom_addr mask", 32'(last_drom_addr), 32'h40DE);

        // R3/R8: aligned word write from a misaligned address, then readback.
        access(32'hE000_4102, 1'b1, 1'b1, 1'b0, 32'h1122_3344);
        check(last_pram_addr == 14'h0103, "R3 pram_addr mask last beat", 32'(last_pram_addr), 32'h0103);
        access(32'hE000_0100, 1'b0, 1'b1, 1'b0, 32'h0);
        check(rsp_rdata == 32'h1122_3344, "R3 RAM word readback", rsp_rdata, 32'h1122_3344);
        access(32'hE000_0101, 1'b0, 1'b0, 1'b0, 32'h0);
        check(rsp_rdata == 32'h0000_0033, "R8 little-endian byte 1", rsp_rdata, 32'h33);

        // R10/R4: fetch a word, then read its lanes through the opcode regions.
        access(32'h0000_0040, 1'b0, 1'b1, 1'b1, 32'h0);
        for (int k = 0; k < 4; k++) access(32'h2000_0000 + 32'(k), 1'b0, 1'b0, 1'b0, 32'h0);
        access(32'h8765_4320, 1'b0, 1'b1, 1'b0, 32'h0);
        check(rsp_rdata == opc_m, "R4 opcode word via region 4", rsp_rdata, opc_m);
        access(32'hC000_0003, 1'b0, 1'b0, 1'b0, 32'h0);
        // R10: a plain read leaves the instruction word alone.
        access(32'h0000_0080, 1'b0, 1'b1, 1'b0, 32'h0);
        access(32'h2000_0000, 1'b0, 1'b1, 1'b0, 32'h0);
        check(rsp_rdata == opc_m, "R10 opcode unchanged by non-fetch", rsp_rdata, opc_m);

        // R5: constant region.
        access(32'h6000_0000, 1'b0, 1'b1, 1'b0, 32'h0);
        check(rsp_rdata == 32'h4040_4001, "R5 constant word", rsp_rdata, 32'h4040_4001);
        access(32'h6123_4562, 1'b0, 1'b0, 1'b0, 32'h0);
        check(rsp_rdata == 32'h40, "R5 constant byte 2", rsp_rdata, 32'h40);

        // R6: I/O byte write with address reduction.
        access(32'h5FFF_FF24, 1'b1, 1'b0, 1'b0, 32'hFFFF_FF5A);
        check(last_io_addr == 32'h4000_0024, "R6 io_addr reduced", last_io_addr, 32'h4000_0024);
        check(last_io_wdata == 8'h5A, "R6 io_wdata", 32'(last_io_wdata), 32'h5A);
        // R6/R8: I/O word write, last beat carries the top byte at offset 3.
        access(32'h4000_0009, 1'b1, 1'b1, 1'b0, 32'hAABB_CCDD);
        check(last_io_addr == 32'h4000_000B, "R6 io word last addr", last_io_addr, 32'h4000_000B);
        check(last_io_wdata == 8'hAA, "R8 io word last byte", 32'(last_io_wdata), 32'hAA);
        // R7: claimed and unclaimed I/O reads.
        access(32'h4000_0010, 1'b0, 1'b0, 1'b0, 32'h0);
        check(rsp_rdata == 32'h2C, "R7 claimed I/O read", rsp_rdata, 32'h2C);
        access(32'h4000_0011, 1'b0, 1'b0, 1'b0, 32'h0);
        check(rsp_rdata == 32'h0, "R7 unclaimed I/O read", rsp_rdata, 32'h0);

        // R9: writes to read-only or fixed regions are dropped.
        access(32'hA000_0100, 1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF);
        access(32'h0000_0100, 1'b1, 1'b0, 1'b0, 32'h0000_0077);
        access(32'h2000_0100, 1'b1, 1'b1, 1'b0, 32'hCAFE_F00D);
        access(32'h6000_0100, 1'b1, 1'b1, 1'b0, 32'h1234_5678);
        access(32'hE000_0100, 1'b0, 1'b1, 1'b0, 32'h0);
        check(rsp_rdata == 32'h1122_3344, "R9 RAM unchanged by dropped writes", rsp_rdata, 32'h1122_3344);
        access(32'h6000_0000, 1'b0, 1'b1, 1'b0, 32'h0);
        check(rsp_rdata == 32'h4040_4001, "R9 constant unchanged", rsp_rdata, 32'h4040_4001);

        // Random mix over all regions and both sizes.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a = $urandom;
            logic        w = ($urandom % 3) == 0;
            logic        wd = $urandom % 2;
            logic        f = !w && (($urandom % 4) == 0);
            if (a[31:29] == 3'd2 && $urandom % 2) a[5:0] = ($urandom % 2) ? 6'h10 : 6'h20;
            access(a, w, wd, f, $urandom);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule